// File: doc/BRIEF.md
# Command Stream Method-Write Decoder

This block sits behind a command-buffer fetch unit and turns a flat stream of 32-bit words into individual register-write transactions. Each transaction carries a method address, a subchannel number and a 32-bit value. The stream is a series of commands. Each command opens with a header word that gives a method address, a subchannel, an argument count and a submission mode. Depending on the mode, the header is followed by argument words or carries an immediate value of its own. The submission mode decides how the method address advances from one argument to the next.

Software-facing logic pulses `start` together with the total number of words in the buffer, headers included. The fetch unit then presents words on a valid/ready input. Writes leave through a valid/ready output register. When the output is stalled, the input is throttled so that no word is lost or repeated. Two sticky error flags report two conditions: a header with an unsupported mode, and a command cut short because the word budget ran out. Both flags clear on the next accepted `start`.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header word is split into fields as follows: method in bits 12:0, subchannel in bits 15:13, argument count in bits 28:16 and mode in bits 31:29. The subchannel of every write equals the subchannel of its header.
- R2: Modes 1 and 0 (0 is the legacy form) issue one write per argument word. The method starts at the header method and rises by one per argument, wrapping modulo 2^13.
- R3: Modes 3 and 2 (2 is the legacy form) write every argument word to the header method.
- R4: Mode 5 writes its first argument to the header method and every later argument to header method + 1. Mode 5 with an argument count of zero is illegal.
- R5: Mode 4 consumes no argument words. It issues exactly one write whose value is header bits 28:16, zero-extended, and the next word is parsed as a header.
- R6: A header with mode 6 or 7, or an illegal mode-5 header, issues no write and sets `err_mode`. Only that header word is skipped, and the next word is parsed as a header. `err_mode` stays set until the next start.
- R7: After `start`, exactly `total_words` input words are accepted. `busy` then falls, and `in_ready` stays low while idle. A `total_words` of zero leaves the block idle.
- R8: If the budget runs out while a command still expects arguments, the writes already issued stand, the command is dropped and `err_trunc` is set.
- R9: While `out_valid` is high and `out_ready` is low, the output fields hold steady. No write is lost or duplicated under any stall pattern.
- R10: After reset, and after a start, both error flags read 0. After reset, `busy`, `out_valid` and `in_ready` also read 0.
- R11: In modes 0 to 3, a header with an argument count of zero issues no write and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a buffer; accepted only while idle |
| total_words | input | BUDGET_W | Words in the buffer, headers included |
| in_valid | input | 1 | Input word valid |
| in_data | input | WORD_W | Input word |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| out_valid | output | 1 | Write transaction valid |
| out_method | output | METHOD_W | Method address of the write |
| out_subch | output | SUBCH_W | Subchannel of the write |
| out_value | output | WORD_W | Value of the write |
| out_ready | input | 1 | Consumer takes the write |
| busy | output | 1 | A buffer is being parsed |
| err_mode | output | 1 | Sticky: unsupported or illegal header seen |
| err_trunc | output | 1 | Sticky: budget ran out inside a command |

## Verification
The bench builds the block with its default parameters: 13-bit method, 3-bit subchannel, 13-bit count, 3-bit mode, 32-bit words, a 16-bit budget and the legacy encodings enabled. With a 13-bit method field, a two-argument incrementing command at method 0x1FFF crosses the wrap point in a short stream. With a 13-bit count, an inline immediate such as 0x1ABC can use the full field width. Because the budget is a runtime input, truncation can be provoked by a three-word budget placed against a four-argument header, and the budget edge can be probed by holding one extra word valid after the budget is spent.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;
   typedef enum logic [2:0] {
      M_INC_OLD = 3'd0,
      M_INC     = 3'd1,
      M_FIX_OLD = 3'd2,
      M_FIX     = 3'd3,
      M_IMM     = 3'd4,
      M_ONCE    = 3'd5
   } mode_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_HDR  = 2'd1,
      S_ARG  = 2'd2
   } state_e;
endpackage

// File: rtl/cmdd_hdr_unpack.sv
module cmdd_hdr_unpack
   import cmdd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int METHOD_W  = 13,
   parameter int SUBCH_W   = 3,
   parameter int COUNT_W   = 13,
   parameter int MODE_W    = 3,
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic [WORD_W-1:0]   word,
   output logic [METHOD_W-1:0] method,
   output logic [SUBCH_W-1:0]  subch,
   output logic [COUNT_W-1:0]  count,
   output mode_e               mode,
   output logic                legal
);
   localparam int SUB_LSB  = METHOD_W;
   localparam int CNT_LSB  = SUB_LSB + SUBCH_W;
   localparam int MODE_LSB = CNT_LSB + COUNT_W;

   logic [MODE_W-1:0] raw_mode;
   logic              known;

   assign method   = word[SUB_LSB-1:0];
   assign subch    = word[CNT_LSB-1:SUB_LSB];
   assign count    = word[MODE_LSB-1:CNT_LSB];
   assign raw_mode = word[MODE_LSB+MODE_W-1:MODE_LSB];
   assign mode     = mode_e'(raw_mode);

   generate
      if (LEGACY_EN) begin : g_legacy
         assign known = (raw_mode <= MODE_W'(5));
      end else begin : g_modern
         assign known = (raw_mode == MODE_W'(1)) || (raw_mode == MODE_W'(3)) ||
                        (raw_mode == MODE_W'(4)) || (raw_mode == MODE_W'(5));
      end
   endgenerate

   assign legal = known && !((mode == M_ONCE) && (count == '0));
endmodule

// File: rtl/cmdd_method_gen.sv
module cmdd_method_gen
   import cmdd_pkg::*;
#(
   parameter int METHOD_W = 13,
   parameter int COUNT_W  = 13
) (
   input  mode_e               mode,
   input  logic [METHOD_W-1:0] base,
   input  logic [COUNT_W-1:0]  idx,
   output logic [METHOD_W-1:0] method
);
   always_comb begin
      unique case (mode)
         M_INC_OLD, M_INC: method = base + METHOD_W'(idx);
         M_ONCE:           method = (idx == '0) ? base : base + METHOD_W'(1);
         default:          method = base;
      endcase
   end
endmodule

// File: rtl/cmdd_budget.sv
module cmdd_budget #(
   parameter int BUDGET_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [BUDGET_W-1:0] load_val,
   input  logic                take,
   output logic                last
);
   logic [BUDGET_W-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem <= '0;
      else if (load) rem <= load_val;
      else if (take) rem <= rem - BUDGET_W'(1);
   end

   assign last = (rem == BUDGET_W'(1));

   p_budget_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !load) |=> (rem == $past(rem) - BUDGET_W'(1)));
   p_no_take_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (rem != '0));
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
   import cmdd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int METHOD_W  = 13,
   parameter int SUBCH_W   = 3,
   parameter int COUNT_W   = 13,
   parameter int MODE_W    = 3,
   parameter int BUDGET_W  = 16,
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BUDGET_W-1:0] total_words,
   input  logic                in_valid,
   input  logic [WORD_W-1:0]   in_data,
   output logic                in_ready,
   output logic                out_valid,
   output logic [METHOD_W-1:0] out_method,
   output logic [SUBCH_W-1:0]  out_subch,
   output logic [WORD_W-1:0]   out_value,
   input  logic                out_ready,
   output logic                busy,
   output logic                err_mode,
   output logic                err_trunc
);
   localparam int FIELD_SUM = METHOD_W + SUBCH_W + COUNT_W + MODE_W;

   generate
      if (FIELD_SUM != WORD_W) begin : g_bad_layout
         $error("header fields must fill the word exactly");
      end
      if (MODE_W != 3) begin : g_bad_mode
         $error("mode field must be 3 bits");
      end
      if (COUNT_W > WORD_W) begin : g_bad_count
         $error("count field wider than word");
      end
   endgenerate

   state_e              state;
   mode_e               cur_mode;
   logic [METHOD_W-1:0] base;
   logic [SUBCH_W-1:0]  subch_r;
   logic [COUNT_W-1:0]  left;
   logic [COUNT_W-1:0]  idx;

   logic [METHOD_W-1:0] h_method;
   logic [SUBCH_W-1:0]  h_subch;
   logic [COUNT_W-1:0]  h_count;
   mode_e               h_mode;
   logic                h_legal;
   logic [METHOD_W-1:0] arg_method;
   logic                last;
   logic                acc, go, emit_hdr, emit_arg;

   cmdd_hdr_unpack #(
      .WORD_W(WORD_W), .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W),
      .COUNT_W(COUNT_W), .MODE_W(MODE_W), .LEGACY_EN(LEGACY_EN)
   ) u_unpack (
      .word(in_data), .method(h_method), .subch(h_subch),
      .count(h_count), .mode(h_mode), .legal(h_legal)
   );

   cmdd_method_gen #(.METHOD_W(METHOD_W), .COUNT_W(COUNT_W)) u_mgen (
      .mode(cur_mode), .base(base), .idx(idx), .method(arg_method)
   );

   cmdd_budget #(.BUDGET_W(BUDGET_W)) u_budget (
      .clk(clk), .rst_n(rst_n), .load(go), .load_val(total_words),
      .take(acc), .last(last)
   );

   assign busy     = (state != S_IDLE);
   assign in_ready = busy && (!out_valid || out_ready);
   assign acc      = in_valid && in_ready;
   assign go       = start && (state == S_IDLE);
   assign emit_hdr = acc && (state == S_HDR) && h_legal && (h_mode == M_IMM);
   assign emit_arg = acc && (state == S_ARG);

   // control path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cur_mode  <= M_INC;
         base      <= '0;
         subch_r   <= '0;
         left      <= '0;
         idx       <= '0;
         err_mode  <= 1'b0;
         err_trunc <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  err_mode  <= 1'b0;
                  err_trunc <= 1'b0;
                  if (total_words != '0) state <= S_HDR;
               end
            end
            S_HDR: begin
               if (acc) begin
                  if (!h_legal) begin
                     err_mode <= 1'b1;
                     state    <= last ? S_IDLE : S_HDR;
                  end else if ((h_mode == M_IMM) || (h_count == '0)) begin
                     state <= last ? S_IDLE : S_HDR;
                  end else begin
                     cur_mode <= h_mode;
                     base     <= h_method;
                     subch_r  <= h_subch;
                     left     <= h_count;
                     idx      <= '0;
                     if (last) begin
                        err_trunc <= 1'b1;
                        state     <= S_IDLE;
                     end else begin
                        state <= S_ARG;
                     end
                  end
               end
            end
            S_ARG: begin
               if (acc) begin
                  left <= left - COUNT_W'(1);
                  idx  <= idx + COUNT_W'(1);
                  if (left == COUNT_W'(1)) begin
                     state <= last ? S_IDLE : S_HDR;
                  end else if (last) begin
                     err_trunc <= 1'b1;
                     state     <= S_IDLE;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_method <= '0;
         out_subch  <= '0;
         out_value  <= '0;
      end else if (emit_hdr) begin
         out_valid  <= 1'b1;
         out_method <= h_method;
         out_subch  <= h_subch;
         out_value  <= WORD_W'(h_count);
      end else if (emit_arg) begin
         out_valid  <= 1'b1;
         out_method <= arg_method;
         out_subch  <= subch_r;
         out_value  <= in_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_method) &&
                                     $stable(out_subch) && $stable(out_value)));
   p_drop_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready));
   p_idle_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_ready);
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_mode && !go) |=> err_mode);
   p_trunc_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_trunc) |-> !busy);
   p_arg_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ARG) |-> (left != '0));
endmodule

// File: tb/sim_cmd_stream_decoder.sv
module sim_cmd_stream_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] total_words = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [12:0] out_method;
   logic [2:0]  out_subch;
   logic [31:0] out_value;
   logic        out_ready;
   logic        busy, err_mode, err_trunc;

   int total = 0;
   int bad = 0;
   bit stall_en = 1'b0;
   int cyc = 0;

   logic [31:0] wbuf [64];
   int          nw;
   logic [47:0] expq [$];
   logic [47:0] gotq [$];

   always #2 clk = ~clk;

   cmd_stream_decoder u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .total_words(total_words),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_method(out_method), .out_subch(out_subch),
      .out_value(out_value), .out_ready(out_ready), .busy(busy),
      .err_mode(err_mode), .err_trunc(err_trunc)
   );

   initial out_ready = 1'b1;
   always @(posedge clk) begin
      #1;
      cyc = cyc + 1;
      out_ready = stall_en ? ((cyc % 3) != 2) && ((cyc % 7) != 0) : 1'b1;
   end

   always @(negedge clk)
      if (rst_n && out_valid && out_ready) gotq.push_back({out_method, out_subch, out_value});

   initial begin
      repeat (200000) @(posedge clk);
      bad = bad + 1;
      $display("FAIL watchdog: run hung, got=%0d expected=completion", total);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input int mode, input int cnt, input int sc, input int m);
      return {mode[2:0], cnt[12:0], sc[2:0], m[12:0]};
   endfunction

   task automatic clear();
      nw = 0;
      expq.delete();
      gotq.delete();
   endtask

   task automatic put(input logic [31:0] w);
      wbuf[nw] = w;
      nw = nw + 1;
   endtask

   task automatic expect_wr(input int m, input int sc, input logic [31:0] v);
      expq.push_back({m[12:0], sc[2:0], v});
   endtask

   task automatic run(input int budget);
      bit acc;
      @(posedge clk); #1;
      start = 1'b1;
      total_words = budget[15:0];
      @(posedge clk); #1;
      start = 1'b0;
      for (int i = 0; i < budget; i++) begin
         in_valid = 1'b1;
         in_data  = wbuf[i];
         do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #1;
         end while (!acc);
      end
      in_valid = 1'b0;
      while (busy || out_valid) @(posedge clk);
      #1;
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic compare(input string req);
      check(gotq.size() == expq.size(), req, gotq.size(), expq.size());
      for (int i = 0; i < expq.size() && i < gotq.size(); i++)
         check(gotq[i] == expq[i], req, gotq[i], expq[i]);
   endtask

   task automatic t_reset();
      check(busy == 1'b0, "R10 busy", busy, 0);
      check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
      check(in_ready == 1'b0, "R10 in_ready", in_ready, 0);
      check(err_mode == 1'b0 && err_trunc == 1'b0, "R10 errs", {err_mode, err_trunc}, 0);
   endtask

   task automatic t_incr();
      clear();
      put(hdr(1, 3, 2, 'h100)); put(32'hA0); put(32'hA1); put(32'hA2);
      put(hdr(0, 2, 7, 'h1FFF)); put(32'hB0); put(32'hB1);
      expect_wr('h100, 2, 32'hA0); expect_wr('h101, 2, 32'hA1); expect_wr('h102, 2, 32'hA2);
      expect_wr('h1FFF, 7, 32'hB0); expect_wr('h0000, 7, 32'hB1);
      run(nw);
      compare("R2 R1 incrementing");
      check(err_mode == 0 && err_trunc == 0, "R2 no error", {err_mode, err_trunc}, 0);
   endtask

   task automatic t_fixed();
      clear();
      put(hdr(3, 2, 1, 'h55)); put(32'hC0); put(32'hC1);
      put(hdr(2, 3, 4, 'h7)); put(32'hD0); put(32'hD1); put(32'hD2);
      expect_wr('h55, 1, 32'hC0); expect_wr('h55, 1, 32'hC1);
      expect_wr('h7, 4, 32'hD0); expect_wr('h7, 4, 32'hD1); expect_wr('h7, 4, 32'hD2);
      run(nw);
      compare("R3 non-incrementing");
   endtask

   task automatic t_once();
      clear();
      put(hdr(5, 4, 3, 'h20)); put(32'h1); put(32'h2); put(32'h3); put(32'h4);
      expect_wr('h20, 3, 32'h1); expect_wr('h21, 3, 32'h2);
      expect_wr('h21, 3, 32'h3); expect_wr('h21, 3, 32'h4);
      run(nw);
      compare("R4 increase-once");
      check(err_mode == 0, "R4 legal once", err_mode, 0);
   endtask

   task automatic t_once_zero();
      clear();
      put(hdr(5, 0, 3, 'h20)); put(hdr(3, 1, 0, 'h9)); put(32'hEE);
      expect_wr('h9, 0, 32'hEE);
      run(nw);
      compare("R4 once count zero skipped");
      check(err_mode == 1, "R4 once count zero flagged", err_mode, 1);
   endtask

   task automatic t_inline();
      clear();
      put(hdr(4, 'h1ABC, 5, 'h44)); put(hdr(4, 'h0003, 6, 'h45)); put(hdr(1, 1, 1, 'h10)); put(32'hF00D);
      expect_wr('h44, 5, 32'h1ABC); expect_wr('h45, 6, 32'h3); expect_wr('h10, 1, 32'hF00D);
      run(nw);
      compare("R5 inline");
   endtask

   task automatic t_illegal();
      clear();
      put(hdr(6, 2, 1, 'h30)); put(hdr(1, 1, 2, 'h31)); put(32'h77);
      put(hdr(7, 0, 0, 'h0)); put(hdr(4, 9, 0, 'h2));
      expect_wr('h31, 2, 32'h77); expect_wr('h2, 0, 32'h9);
      run(nw);
      compare("R6 illegal skipped");
      check(err_mode == 1, "R6 err_mode set", err_mode, 1);
      check(err_trunc == 0, "R6 no trunc", err_trunc, 0);
   endtask

   task automatic t_clear_on_start();
      clear();
      put(hdr(4, 1, 0, 'h1));
      expect_wr('h1, 0, 32'h1);
      run(nw);
      compare("R10 clean run");
      check(err_mode == 0, "R10 start clears err_mode", err_mode, 0);
   endtask

   task automatic t_zero_cnt();
      clear();
      put(hdr(1, 0, 1, 'h11)); put(hdr(3, 0, 1, 'h12)); put(hdr(4, 5, 1, 'h13));
      expect_wr('h13, 1, 32'h5);
      run(nw);
      compare("R11 zero-count");
      check(err_mode == 0 && err_trunc == 0, "R11 no error", {err_mode, err_trunc}, 0);
   endtask

   task automatic t_trunc();
      clear();
      put(hdr(1, 4, 2, 'h40)); put(32'h10); put(32'h11);
      expect_wr('h40, 2, 32'h10); expect_wr('h41, 2, 32'h11);
      run(nw);
      compare("R8 truncated writes");
      check(err_trunc == 1, "R8 err_trunc", err_trunc, 1);
      check(busy == 0, "R8 idle", busy, 0);
      clear();
      put(hdr(3, 2, 0, 'h50));
      run(nw);
      compare("R8 header-only truncation");
      check(err_trunc == 1, "R8 err_trunc header", err_trunc, 1);
   endtask

   task automatic t_budget();
      clear();
      put(hdr(1, 1, 0, 'h60)); put(32'h99);
      expect_wr('h60, 0, 32'h99);
      run(nw);
      in_valid = 1'b1;
      in_data  = hdr(4, 1, 0, 'h61);
      repeat (4) begin
         @(negedge clk);
         check(in_ready == 0, "R7 no accept after budget", in_ready, 0);
      end
      in_valid = 1'b0;
      @(posedge clk); #1;
      compare("R7 budget exact");
      check(busy == 0 && err_trunc == 0, "R7 ended cleanly", {busy, err_trunc}, 0);
      clear();
      @(posedge clk); #1;
      start = 1'b1; total_words = '0;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      check(busy == 0, "R7 zero budget idle", busy, 0);
   endtask

   task automatic t_stall();
      clear();
      put(hdr(1, 6, 3, 'h200));
      for (int i = 0; i < 6; i++) begin
         put(32'h500 + i);
         expect_wr('h200 + i, 3, 32'h500 + i);
      end
      put(hdr(5, 3, 4, 'h300)); put(32'h1); put(32'h2); put(32'h3);
      expect_wr('h300, 4, 32'h1); expect_wr('h301, 4, 32'h2); expect_wr('h301, 4, 32'h3);
      put(hdr(4, 'h123, 1, 'h8));
      expect_wr('h8, 1, 32'h123);
      stall_en = 1'b1;
      run(nw);
      stall_en = 1'b0;
      compare("R9 stalled output");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_incr();
      t_fixed();
      t_once();
      t_once_zero();
      t_inline();
      t_illegal();
      t_clear_on_start();
      t_zero_cnt();
      t_trunc();
      t_budget();
      t_stall();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule